// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Engine

This block builds a Hamming-style check code over one NAND sector while the sector's bytes stream past, one byte per valid cycle. Every data bit has a 12-bit bit address (byte index times eight plus bit index). Two 12-bit parity halves are accumulated from the addresses of all 1 bits. The halves are squeezed into a 24-bit code and inverted. Because of the inversion, an erased sector of all-0xFF data, stored with an all-0xFF code, reads back as clean.

On the read path the stored 3-byte code is presented next to the freshly computed one. A one-cycle check request classifies the difference into four outcomes: clean, one correctable data bit (reported with its byte index and a one-hot bit mask), an error confined to the code bytes, or uncorrectable. Fixing the data in the sector buffer is left to the user of the block. A start pulse opens a new sector.

Top module: `ecc_sector_engine`

## Requirements
- R1: After reset, code_valid, status_valid, status, err_byte and err_mask are all zero.
- R2: Let U be the XOR of the 12-bit addresses (byte_index*8 + bit_index) of every 1 data bit, and L the XOR of the bitwise complements of those addresses. Then code_out is the bitwise inverse of {U, L}, with U in bits 23:12. The first stored code byte is code_out[7:0], then bits 15:8, then bits 23:16.
- R3: A sector of all-0xFF bytes yields code_out = 0xFFFFFF, and a check against a stored 0xFFFFFF gives status 0.
- R4: code_valid goes high in the cycle after the last byte of the sector is accepted. Cycles with in_valid low are not counted. code_valid and code_out then hold until the next start.
- R5: Bytes offered after the sector is complete are ignored and leave code_out unchanged.
- R6: start clears the accumulated code and drops code_valid. A byte offered with in_valid in the same cycle as start is taken as byte 0 of the new sector.
- R7: A check request (chk_req) in a cycle with code_valid high gives a one-cycle status_valid pulse in the next cycle. A check request while code_valid is low is ignored: no pulse, and the previous results stay.
- R8: Let D = code_out XOR stored_code. If D is zero, status is 0 (clean).
- R9: If D[23:12] XOR D[11:0] equals 0xFFF and D[23:15] is below SECTOR_BYTES, status is 1 (corrected). err_byte is then D[23:15] and err_mask has only bit D[14:12] set.
- R10: If D[23:12] XOR D[11:0] equals 0xFFF but D[23:15] is SECTOR_BYTES or more, status is 3 (uncorrectable).
- R11: Otherwise, if exactly one bit of D is set, status is 2 (error in the code only, data good).
- R12: Any other nonzero D gives status 3. For every status except 1, err_byte and err_mask are zero.
- R13: A check request and a start in the same cycle judge the finished code of the old sector, while the new sector begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new sector, clearing the code |
| in_valid | input | 1 | in_byte carries a sector byte |
| in_byte | input | 8 | Sector data byte |
| chk_req | input | 1 | Compare stored_code against the computed code |
| stored_code | input | 24 | Code read back from the spare area, first byte in bits 7:0 |
| code_out | output | 24 | Computed stored-form code, first byte in bits 7:0 |
| code_valid | output | 1 | code_out covers a complete sector |
| status_valid | output | 1 | One-cycle pulse: check results updated |
| status | output | 2 | 0 clean, 1 corrected, 2 code-only error, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the corrected bit |
| err_mask | output | 8 | One-hot mask of the corrected bit |

## Verification
The check of one sector and the start of the next can fall in the same cycle. That is the normal back-to-back read, where the verdict on sector N is taken as sector N+1 begins. The bench raises start, chk_req and in_valid together, offering byte 0 of the new sector with the stored code of the old one. It then expects two things: the verdict reflects the old sector's finished code, and the new sector's code, once complete, matches a model that counts that overlapping byte as byte 0.

// File: rtl/ecc_sector_pkg.sv
// Package: shared widths and the status encoding of the sector ECC engine.
// Assumes byte-wide data and the fixed 12-bit half / 24-bit code format.
package ecc_sector_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int HALF_W    = 12;
    localparam int CODE_W    = 2 * HALF_W;
    localparam int LOC_W     = HALF_W - BIT_IDX_W;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FIXED     = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_BAD       = 2'd3
    } ecc_status_e;
endpackage

// File: rtl/ecc_accum.sv
// Module: ecc_accum
// Accumulates the two 12-bit parity halves over a sector streamed one byte
// per valid cycle. The upper half XORs the bit address of every 1 bit and
// the lower half XORs the complement of those addresses.
// Assumes SECTOR_BYTES*8 fits in 12 address bits (SECTOR_BYTES <= 512).
module ecc_accum
    import ecc_sector_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [HALF_W-1:0] par_hi,
    output logic [HALF_W-1:0] par_lo,
    output logic              done
);
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SECTOR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SECTOR_BYTES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic              take;
    logic [HALF_W-1:0] bit_addr [BYTE_W];
    logic [HALF_W-1:0] contrib_hi;
    logic [HALF_W-1:0] contrib_lo;
    logic [HALF_W-1:0] base_hi;
    logic [HALF_W-1:0] base_lo;

    // A start restarts the byte count in the same cycle it is raised.
    assign cnt_eff = start ? '0 : cnt_q;
    assign take    = in_valid && (cnt_eff < CNT_FULL);
    assign base_hi = start ? '0 : par_hi;
    assign base_lo = start ? '0 : par_lo;

    // One bit address per lane of the incoming byte.
    generate
        for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
            assign bit_addr[b] = {LOC_W'(cnt_eff), BIT_IDX_W'(b)};
        end
    endgenerate

    // Fold the addresses of the set bits of this byte into both halves.
    always_comb begin
        contrib_hi = '0;
        contrib_lo = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            if (in_byte[b]) begin
                contrib_hi = contrib_hi ^ bit_addr[b];
                contrib_lo = contrib_lo ^ ~bit_addr[b];
            end
        end
    end

    // Count accepted bytes, update the halves and flag sector completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            par_hi <= '0;
            par_lo <= '0;
            done   <= 1'b0;
        end else begin
            if (take) begin
                cnt_q  <= cnt_eff + 1'b1;
                par_hi <= base_hi ^ contrib_hi;
                par_lo <= base_lo ^ contrib_lo;
            end else if (start) begin
                cnt_q  <= '0;
                par_hi <= '0;
                par_lo <= '0;
            end
            done <= (take && (cnt_eff == CNT_LAST)) || (done && !start);
        end
    end
endmodule

// File: rtl/ecc_pack.sv
// Module: ecc_pack
// Squeezes the two parity halves into the 24-bit code and inverts it so an
// erased sector (all ones, code all ones) compares clean.
// Assumes the upper half lands in code bits 23:12.
module ecc_pack
    import ecc_sector_pkg::*;
(
    input  logic [HALF_W-1:0] par_hi,
    input  logic [HALF_W-1:0] par_lo,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] packed_code;

    // Join the halves, upper half on top.
    assign packed_code = {par_hi, par_lo};
    // Inversion gives the stored form; byte 0 of the spare area is bits 7:0.
    assign code = ~packed_code;
endmodule

// File: rtl/ecc_decode.sv
// Module: ecc_decode
// Classifies the difference between the computed and the stored code.
// Complementary halves flag a single data bit; a lone set bit flags the
// code itself. Purely combinational; the top registers the result.
module ecc_decode
    import ecc_sector_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] computed,
    input  logic [CODE_W-1:0] stored,
    output ecc_status_e       status,
    output logic [LOC_W-1:0]  err_byte,
    output logic [BYTE_W-1:0] err_mask
);
    logic [CODE_W-1:0]    diff;
    logic [HALF_W-1:0]    d_hi;
    logic [HALF_W-1:0]    d_lo;
    logic [LOC_W-1:0]     loc;
    logic [BIT_IDX_W-1:0] bit_n;
    logic                 halves_compl;
    logic                 single_bit;
    logic                 in_range;

    assign diff         = computed ^ stored;
    assign d_hi         = diff[CODE_W-1:HALF_W];
    assign d_lo         = diff[HALF_W-1:0];
    assign loc          = d_hi[HALF_W-1:BIT_IDX_W];
    assign bit_n        = d_hi[BIT_IDX_W-1:0];
    assign halves_compl = ((d_hi ^ d_lo) == '1);
    assign single_bit   = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
    assign in_range     = (int'(loc) < SECTOR_BYTES);

    // Pick the verdict; location fields only for a correctable data bit.
    always_comb begin
        status   = ST_BAD;
        err_byte = '0;
        err_mask = '0;
        if (diff == '0) begin
            status = ST_CLEAN;
        end else if (halves_compl) begin
            if (in_range) begin
                status   = ST_FIXED;
                err_byte = loc;
                err_mask = BYTE_W'(1) << bit_n;
            end
        end else if (single_bit) begin
            status = ST_CODE_ONLY;
        end
    end
endmodule

// File: rtl/ecc_sector_engine.sv
// Module: ecc_sector_engine (top)
// Streams a sector into the parity accumulator, presents the stored-form
// code once the sector is complete, and registers a check verdict one cycle
// after a check request made while the code is valid.
// Assumes SECTOR_BYTES <= 512 and at most one byte per cycle.
module ecc_sector_engine
    import ecc_sector_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              chk_req,
    input  logic [23:0]       stored_code,
    output logic [23:0]       code_out,
    output logic              code_valid,
    output logic              status_valid,
    output logic [1:0]        status,
    output logic [8:0]        err_byte,
    output logic [7:0]        err_mask
);
    logic [HALF_W-1:0] par_hi;
    logic [HALF_W-1:0] par_lo;
    ecc_status_e       dec_status;
    logic [LOC_W-1:0]  dec_byte;
    logic [BYTE_W-1:0] dec_mask;
    logic              chk_take;

    ecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .par_hi   (par_hi),
        .par_lo   (par_lo),
        .done     (code_valid)
    );

    ecc_pack u_pack (
        .par_hi (par_hi),
        .par_lo (par_lo),
        .code   (code_out)
    );

    ecc_decode #(.SECTOR_BYTES(SECTOR_BYTES)) u_decode (
        .computed (code_out),
        .stored   (stored_code),
        .status   (dec_status),
        .err_byte (dec_byte),
        .err_mask (dec_mask)
    );

    // A check counts only against a finished sector code.
    assign chk_take = chk_req && code_valid;

    // Capture the verdict and pulse status_valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_valid <= 1'b0;
            status       <= 2'd0;
            err_byte     <= '0;
            err_mask     <= '0;
        end else begin
            status_valid <= chk_take;
            if (chk_take) begin
                status   <= dec_status;
                err_byte <= dec_byte;
                err_mask <= dec_mask;
            end
        end
    end
endmodule

// File: rtl/ecc_sector_engine_sva.sv
// Module: ecc_sector_engine_sva
// Checker bound to the top: relates the handshake, held code and verdict
// fields over time.
module ecc_sector_engine_sva #(
    parameter int SECTOR_BYTES = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        in_valid,
    input logic [7:0]  in_byte,
    input logic        chk_req,
    input logic [23:0] stored_code,
    input logic [23:0] code_out,
    input logic        code_valid,
    input logic        status_valid,
    input logic [1:0]  status,
    input logic [8:0]  err_byte,
    input logic [7:0]  err_mask
);
    // R4, R5: a finished code holds until start
    a_r4_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !start) |=> (code_valid && $stable(code_out)));

    // R6: start without a byte leaves no valid code
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_valid) |=> !code_valid);

    // R7: accepted check gives a pulse next cycle
    a_r7_check_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && code_valid) |=> status_valid);

    // R7: no pulse without an accepted check
    a_r7_check_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_req && code_valid) |=> !status_valid);

    // R8: a clean verdict means the codes matched
    a_r8_clean_match: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status == 2'd0) |-> ($past(stored_code) == $past(code_out)));

    // R9, R10: a correction names one bit inside the sector
    a_r9_fix_location: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status == 2'd1) |->
            ($countones(err_mask) == 1 && int'(err_byte) < SECTOR_BYTES));

    // R12: other verdicts carry no location
    a_r12_no_location: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status != 2'd1) |-> (err_mask == 8'd0 && err_byte == 9'd0));
endmodule

bind ecc_sector_engine ecc_sector_engine_sva #(.SECTOR_BYTES(SECTOR_BYTES)) u_sva (.*);

// File: tb/ecc_sector_engine_tb.sv
`timescale 1ns/1ps
module ecc_sector_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, in_valid = 1'b0, chk_req = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [23:0] stored_code = '0;
    logic [23:0] code_out;
    logic        code_valid, status_valid;
    logic [1:0]  status;
    logic [8:0]  err_byte;
    logic [7:0]  err_mask;

    logic        s_start = 1'b0, s_valid = 1'b0, s_chk = 1'b0;
    logic [7:0]  s_byte = '0;
    logic [23:0] s_stored = '0;
    logic [23:0] s_code;
    logic        s_code_valid, s_status_valid;
    logic [1:0]  s_status;
    logic [8:0]  s_err_byte;
    logic [7:0]  s_err_mask;

    int errors = 0, checks = 0;
    bit finished = 0;
    logic [7:0] mem [0:519];

    always #4 clk = ~clk;

    ecc_sector_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_byte(in_byte), .chk_req(chk_req), .stored_code(stored_code),
        .code_out(code_out), .code_valid(code_valid), .status_valid(status_valid),
        .status(status), .err_byte(err_byte), .err_mask(err_mask));

    ecc_sector_engine #(.SECTOR_BYTES(4)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .start(s_start), .in_valid(s_valid),
        .in_byte(s_byte), .chk_req(s_chk), .stored_code(s_stored),
        .code_out(s_code), .code_valid(s_code_valid), .status_valid(s_status_valid),
        .status(s_status), .err_byte(s_err_byte), .err_mask(s_err_mask));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model: XOR of bit addresses of 1 bits and of their complements, inverted.
    function automatic logic [23:0] model_code(int nbytes);
        logic [11:0] u = '0, l = '0;
        for (int i = 0; i < nbytes; i++)
            for (int b = 0; b < 8; b++)
                if (mem[i][b]) begin
                    u ^= 12'(i * 8 + b);
                    l ^= ~12'(i * 8 + b);
                end
        return ~{u, l};
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(int first, int n, int gap);
        for (int i = first; i < first + n; i++) begin
            in_valid = 1'b1;
            in_byte  = mem[i];
            @(negedge clk);
            if (gap > 0) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic do_check(logic [23:0] s);
        chk_req     = 1'b1;
        stored_code = s;
        @(negedge clk);
        chk_req = 1'b0;
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < 520; i++) mem[i] = 8'((i * 37 + seed) ^ (i >> 3));
    endtask

    task automatic t_reset();
        check("R1 code_valid", 32'(code_valid), 0);
        check("R1 status_valid", 32'(status_valid), 0);
        check("R1 status", 32'(status), 0);
        check("R1 err_byte", 32'(err_byte), 0);
        check("R1 err_mask", 32'(err_mask), 0);
    endtask

    task automatic t_erased();
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        pulse_start();
        feed(0, 512, 0);
        check("R3 erased code", 32'(code_out), 32'hFFFFFF);
        do_check(24'hFFFFFF);
        check("R3 erased pulse", 32'(status_valid), 1);
        check("R3 erased status", 32'(status), 0);
    endtask

    task automatic t_timing_and_code();
        logic [23:0] exp;
        fill(5);
        exp = model_code(512);
        pulse_start();
        check("R6 invalid after start", 32'(code_valid), 0);
        feed(0, 511, 1);
        check("R4 not valid before last byte", 32'(code_valid), 0);
        feed(511, 1, 0);
        check("R4 valid after last byte", 32'(code_valid), 1);
        check("R2 code gapped stream", 32'(code_out), 32'(exp));
        do_check(exp);
        check("R8 clean status", 32'(status), 0);
        feed(512, 8, 0);
        check("R5 code after extra bytes", 32'(code_out), 32'(exp));
        check("R5 still valid", 32'(code_valid), 1);
        check("R7 pulse one cycle", 32'(status_valid), 0);
    endtask

    task automatic t_single(int byte_i, int bit_i);
        logic [23:0] exp;
        fill(byte_i + 11);
        exp = model_code(512);
        mem[byte_i][bit_i] = ~mem[byte_i][bit_i];
        pulse_start();
        feed(0, 512, 0);
        check("R2 code corrupted sector", 32'(code_out), 32'(model_code(512)));
        do_check(exp);
        check("R9 status", 32'(status), 1);
        check("R9 err_byte", 32'(err_byte), 32'(byte_i));
        check("R9 err_mask", 32'(err_mask), 32'(1 << bit_i));
    endtask

    task automatic t_code_only(int k);
        logic [23:0] exp;
        exp = code_out;
        do_check(exp ^ (24'd1 << k));
        check("R11 status", 32'(status), 2);
        check("R12 no mask on code error", 32'(err_mask), 0);
    endtask

    task automatic t_double();
        logic [23:0] exp;
        fill(77);
        exp = model_code(512);
        mem[3][1] = ~mem[3][1];
        mem[200][6] = ~mem[200][6];
        pulse_start();
        feed(0, 512, 0);
        do_check(exp);
        check("R12 double status", 32'(status), 3);
        check("R12 double byte", 32'(err_byte), 0);
    endtask

    task automatic t_ignored_check();
        fill(9);
        pulse_start();
        feed(0, 100, 0);
        do_check(24'h000000);
        check("R7 ignored no pulse", 32'(status_valid), 0);
        check("R7 ignored status kept", 32'(status), 3);
        feed(100, 412, 0);
    endtask

    task automatic t_overlap();
        logic [23:0] exp_a, exp_b;
        fill(21);
        exp_a = model_code(512);
        pulse_start();
        feed(0, 512, 0);
        fill(99);
        exp_b = model_code(512);
        start = 1'b1; chk_req = 1'b1; stored_code = exp_a;
        in_valid = 1'b1; in_byte = mem[0];
        @(negedge clk);
        start = 1'b0; chk_req = 1'b0; in_valid = 1'b0;
        check("R13 overlap pulse", 32'(status_valid), 1);
        check("R13 overlap judged old sector", 32'(status), 0);
        check("R6 new sector not valid", 32'(code_valid), 0);
        feed(1, 511, 0);
        check("R6 byte with start counted", 32'(code_out), 32'(exp_b));
    endtask

    task automatic t_small_range();
        s_start = 1'b1; @(negedge clk); s_start = 1'b0;
        s_valid = 1'b1; s_byte = 8'h00;
        repeat (4) @(negedge clk);
        s_valid = 1'b0;
        check("R4 small valid", 32'(s_code_valid), 1);
        s_chk = 1'b1; s_stored = 24'hFFFFFF ^ {12'(100 * 8 + 2), ~12'(100 * 8 + 2)};
        @(negedge clk); s_chk = 1'b0;
        check("R10 out of range", 32'(s_status), 3);
        check("R10 no location", 32'(s_err_mask), 0);
        s_chk = 1'b1; s_stored = 24'hFFFFFF ^ {12'(2 * 8 + 5), ~12'(2 * 8 + 5)};
        @(negedge clk); s_chk = 1'b0;
        check("R9 small in range", 32'(s_status), 1);
        check("R9 small mask", 32'(s_err_mask), 32'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erased();
        t_timing_and_code();
        t_single(0, 0);
        t_single(511, 7);
        t_single(260, 3);
        t_code_only(0);
        t_code_only(17);
        t_double();
        t_ignored_check();
        t_overlap();
        t_small_range();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule